// File: doc/BRIEF.md
# Four-Bank Butterfly Operand Scheduler

This block sits between an operand sequencer, a single pipelined radix-2 butterfly and four independent single-port memory banks. Each cycle, the sequencer may present one operand pair. A pair is two row addresses, each with its own bank number. The block issues the two reads to the addressed banks. The bank outputs are registered, so read data returns one cycle after issue. The block steers that data to the butterfly's A and B inputs, using the bank numbers it recorded at issue time.

The butterfly returns its two results `LAT` cycles after the read was issued. The block writes them back in place, to the same bank and row each operand came from. In steady state, the writeback of pair k falls in the same cycle as the reads of pair k+1. Four accesses then share one cycle, and they must reach four different banks.

A per-bank hit counter watches every cycle. If any bank would receive two accesses, it sets a sticky error flag. The cycle is still issued, with a fixed priority: read A, then read B, then write A, then write B. Once the last pair has been read, the block drains the pending writes. It then pulses `done` for one cycle.

Top module: `bfs_sched`

## Requirements
- R1: After reset, no bank is selected, `bank_we` is 0, `conflict_err` is 0 and `done` is 0.
- R2: When `op_valid` is high and the two bank numbers differ, bank `op_bank_a` is selected in that same cycle as a read (`bank_we` bit 0) at row `op_row_a`. Bank `op_bank_b` is selected the same way at row `op_row_b`. Bank n uses `bank_sel[n]` and `bank_addr[n*ROW_W +: ROW_W]`.
- R3: `LAT` cycles after a pair was issued, both of its locations are written (`bank_we` bit 1). Each write goes to the bank and row of its operand. The data is `bf_res_a` for operand A and `bf_res_b` for operand B.
- R4: One cycle after a pair is issued, `bf_opnd_a` carries the read data of operand A's bank and `bf_opnd_b` carries the read data of operand B's bank.
- R5: Suppose the writes of one pair and the reads of the next target four distinct banks. Then all four banks are active in that cycle and `conflict_err` stays 0.
- R6: If any bank is targeted by two accesses in one cycle, `conflict_err` is 1 from the next cycle on and stays 1 until reset.
- R7: When a write and a read target the same bank in one cycle, that bank performs the read, at the read's row, with `bank_we` 0.
- R8: When both reads of a pair target the same bank, that bank uses operand A's row.
- R9: After the pair marked `op_last`, the next `LAT` cycles carry only the pending writes. In the cycle after the last write, `done` is 1 for exactly one cycle.
- R10: In a cycle with no pair issued and no write pending, `bank_sel` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operand pair is presented this cycle |
| op_last | input | 1 | The presented pair is the last of the run |
| op_row_a | input | ROW_W | Row of operand A |
| op_bank_a | input | BANK_W | Bank of operand A |
| op_row_b | input | ROW_W | Row of operand B |
| op_bank_b | input | BANK_W | Bank of operand B |
| bank_sel | output | 2**BANK_W | Per-bank access select |
| bank_we | output | 2**BANK_W | Per-bank write enable (0 = read) |
| bank_addr | output | 2**BANK_W*ROW_W | Per-bank row address |
| bank_wdata | output | 2**BANK_W*DATA_W | Per-bank write data |
| bank_rdata | input | 2**BANK_W*DATA_W | Per-bank registered read data |
| bf_opnd_a | output | DATA_W | Operand A to the butterfly |
| bf_opnd_b | output | DATA_W | Operand B to the butterfly |
| bf_res_a | input | DATA_W | Butterfly result for operand A |
| bf_res_b | input | DATA_W | Butterfly result for operand B |
| conflict_err | output | 1 | Sticky flag: a bank was targeted twice in one cycle |
| done | output | 1 | One-cycle pulse after the last writeback |

## Verification
Suppose the writeback pipeline holds a wrong row or bank. The result then lands in the wrong place, and this shows up in the memory image at the end of a pass. Within `LAT` cycles it also shows as an unexpected select pattern on the bank ports.

Suppose instead that the recorded read banks are wrong. Then `bf_opnd_a`/`bf_opnd_b` are wrong one cycle after issue, and every later result built from them is wrong too.

A fault in the hit counter or the priority logic shows up in the cycle of the collision itself. It appears as the wrong port action, and one cycle later as a wrong `conflict_err`.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

  typedef enum logic [2:0] {
    ACT_IDLE = 3'd0,
    ACT_RD_A = 3'd1,
    ACT_RD_B = 3'd2,
    ACT_WR_A = 3'd3,
    ACT_WR_B = 3'd4
  } port_act_e;

  // Number of accesses aimed at bank k this cycle.
  function automatic int unsigned bank_hits(logic rd_v, logic wr_v,
                                            int unsigned rba, int unsigned rbb,
                                            int unsigned wba, int unsigned wbb,
                                            int unsigned k);
    int unsigned n;
    n = 0;
    if (rd_v && rba == k) n++;
    if (rd_v && rbb == k) n++;
    if (wr_v && wba == k) n++;
    if (wr_v && wbb == k) n++;
    return n;
  endfunction

  // Fixed priority: read A, read B, write A, write B.
  function automatic port_act_e pick_act(logic hit_ra, logic hit_rb,
                                         logic hit_wa, logic hit_wb);
    if (hit_ra) return ACT_RD_A;
    if (hit_rb) return ACT_RD_B;
    if (hit_wa) return ACT_WR_A;
    if (hit_wb) return ACT_WR_B;
    return ACT_IDLE;
  endfunction

endpackage

// File: rtl/bfs_wb_pipe.sv
module bfs_wb_pipe #(
  parameter int ROW_W  = 3,
  parameter int BANK_W = 2,
  parameter int LAT    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_last,
  input  logic [ROW_W-1:0]  in_row_a,
  input  logic [BANK_W-1:0] in_bank_a,
  input  logic [ROW_W-1:0]  in_row_b,
  input  logic [BANK_W-1:0] in_bank_b,
  output logic              wr_valid,
  output logic              wr_last,
  output logic [ROW_W-1:0]  wr_row_a,
  output logic [BANK_W-1:0] wr_bank_a,
  output logic [ROW_W-1:0]  wr_row_b,
  output logic [BANK_W-1:0] wr_bank_b
);
  logic              st_v    [LAT];
  logic              st_last [LAT];
  logic [ROW_W-1:0]  st_ra   [LAT];
  logic [BANK_W-1:0] st_ba   [LAT];
  logic [ROW_W-1:0]  st_rb   [LAT];
  logic [BANK_W-1:0] st_bb   [LAT];

  for (genvar i = 0; i < LAT; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          st_v[i]    <= 1'b0;
          st_last[i] <= 1'b0;
        end else begin
          st_v[i]    <= in_valid;
          st_last[i] <= in_valid & in_last;
        end
        st_ra[i] <= in_row_a;
        st_ba[i] <= in_bank_a;
        st_rb[i] <= in_row_b;
        st_bb[i] <= in_bank_b;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          st_v[i]    <= 1'b0;
          st_last[i] <= 1'b0;
        end else begin
          st_v[i]    <= st_v[i-1];
          st_last[i] <= st_last[i-1];
        end
        st_ra[i] <= st_ra[i-1];
        st_ba[i] <= st_ba[i-1];
        st_rb[i] <= st_rb[i-1];
        st_bb[i] <= st_bb[i-1];
      end
    end
  end

  assign wr_valid  = st_v[LAT-1];
  assign wr_last   = st_last[LAT-1];
  assign wr_row_a  = st_ra[LAT-1];
  assign wr_bank_a = st_ba[LAT-1];
  assign wr_row_b  = st_rb[LAT-1];
  assign wr_bank_b = st_bb[LAT-1];

  // R9: the last flag never travels without a valid pair
  assert_last_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_last |-> wr_valid);
endmodule

// File: rtl/bfs_conflict.sv
module bfs_conflict
  import bfs_pkg::*;
#(
  parameter int BANK_W = 2,
  localparam int NB    = 1 << BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  input  logic [BANK_W-1:0] rd_bank_a,
  input  logic [BANK_W-1:0] rd_bank_b,
  input  logic              wr_valid,
  input  logic [BANK_W-1:0] wr_bank_a,
  input  logic [BANK_W-1:0] wr_bank_b,
  output logic              conflict_now,
  output logic              conflict_err
);
  logic [NB-1:0] over;

  for (genvar k = 0; k < NB; k++) begin : g_cnt
    assign over[k] = bank_hits(rd_valid, wr_valid,
                               int'(rd_bank_a), int'(rd_bank_b),
                               int'(wr_bank_a), int'(wr_bank_b), k) > 1;
  end

  assign conflict_now = |over;

  always_ff @(posedge clk) begin
    if (!rst_n)            conflict_err <= 1'b0;
    else if (conflict_now) conflict_err <= 1'b1;
  end

  assert_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_now |=> conflict_err);
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    conflict_err |=> conflict_err);
endmodule

// File: rtl/bfs_port_mux.sv
module bfs_port_mux
  import bfs_pkg::*;
#(
  parameter int ROW_W  = 3,
  parameter int BANK_W = 2,
  parameter int DATA_W = 16,
  localparam int NB    = 1 << BANK_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_valid,
  input  logic [ROW_W-1:0]     rd_row_a,
  input  logic [BANK_W-1:0]    rd_bank_a,
  input  logic [ROW_W-1:0]     rd_row_b,
  input  logic [BANK_W-1:0]    rd_bank_b,
  input  logic                 wr_valid,
  input  logic [ROW_W-1:0]     wr_row_a,
  input  logic [BANK_W-1:0]    wr_bank_a,
  input  logic [ROW_W-1:0]     wr_row_b,
  input  logic [BANK_W-1:0]    wr_bank_b,
  input  logic [DATA_W-1:0]    wr_data_a,
  input  logic [DATA_W-1:0]    wr_data_b,
  output logic [NB-1:0]        bank_sel,
  output logic [NB-1:0]        bank_we,
  output logic [NB*ROW_W-1:0]  bank_addr,
  output logic [NB*DATA_W-1:0] bank_wdata
);
  for (genvar k = 0; k < NB; k++) begin : g_bank
    localparam int unsigned KI = k;
    logic hit_ra, hit_rb, hit_wa, hit_wb;
    port_act_e act;

    assign hit_ra = rd_valid && rd_bank_a == BANK_W'(KI);
    assign hit_rb = rd_valid && rd_bank_b == BANK_W'(KI);
    assign hit_wa = wr_valid && wr_bank_a == BANK_W'(KI);
    assign hit_wb = wr_valid && wr_bank_b == BANK_W'(KI);
    assign act    = pick_act(hit_ra, hit_rb, hit_wa, hit_wb);

    always_comb begin
      bank_sel[k] = act != ACT_IDLE;
      bank_we[k]  = act == ACT_WR_A || act == ACT_WR_B;
      bank_wdata[k*DATA_W +: DATA_W] = '0;
      unique case (act)
        ACT_RD_A: bank_addr[k*ROW_W +: ROW_W] = rd_row_a;
        ACT_RD_B: bank_addr[k*ROW_W +: ROW_W] = rd_row_b;
        ACT_WR_A: begin
          bank_addr[k*ROW_W +: ROW_W]    = wr_row_a;
          bank_wdata[k*DATA_W +: DATA_W] = wr_data_a;
        end
        ACT_WR_B: begin
          bank_addr[k*ROW_W +: ROW_W]    = wr_row_b;
          bank_wdata[k*DATA_W +: DATA_W] = wr_data_b;
        end
        default:  bank_addr[k*ROW_W +: ROW_W] = '0;
      endcase
    end

    assert_read_pri_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_ra || hit_rb) |-> (bank_sel[k] && !bank_we[k]));
    assert_rd_a_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hit_ra |-> bank_addr[k*ROW_W +: ROW_W] == rd_row_a);
  end
endmodule

// File: rtl/bfs_rd_steer.sv
module bfs_rd_steer #(
  parameter int BANK_W = 2,
  parameter int DATA_W = 16,
  localparam int NB    = 1 << BANK_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_valid,
  input  logic [BANK_W-1:0]    rd_bank_a,
  input  logic [BANK_W-1:0]    rd_bank_b,
  input  logic [NB*DATA_W-1:0] bank_rdata,
  output logic [DATA_W-1:0]    opnd_a,
  output logic [DATA_W-1:0]    opnd_b
);
  logic [BANK_W-1:0] src_a_q, src_b_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_a_q <= '0;
      src_b_q <= '0;
    end else if (rd_valid) begin
      src_a_q <= rd_bank_a;
      src_b_q <= rd_bank_b;
    end
  end

  assign opnd_a = bank_rdata[int'(src_a_q)*DATA_W +: DATA_W];
  assign opnd_b = bank_rdata[int'(src_b_q)*DATA_W +: DATA_W];

  assert_src_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> $stable(src_a_q) && $stable(src_b_q));
endmodule

// File: rtl/bfs_sched.sv
module bfs_sched #(
  parameter int ROW_W  = 3,
  parameter int BANK_W = 2,
  parameter int DATA_W = 16,
  parameter int LAT    = 1,
  localparam int NB    = 1 << BANK_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 op_valid,
  input  logic                 op_last,
  input  logic [ROW_W-1:0]     op_row_a,
  input  logic [BANK_W-1:0]    op_bank_a,
  input  logic [ROW_W-1:0]     op_row_b,
  input  logic [BANK_W-1:0]    op_bank_b,
  output logic [NB-1:0]        bank_sel,
  output logic [NB-1:0]        bank_we,
  output logic [NB*ROW_W-1:0]  bank_addr,
  output logic [NB*DATA_W-1:0] bank_wdata,
  input  logic [NB*DATA_W-1:0] bank_rdata,
  output logic [DATA_W-1:0]    bf_opnd_a,
  output logic [DATA_W-1:0]    bf_opnd_b,
  input  logic [DATA_W-1:0]    bf_res_a,
  input  logic [DATA_W-1:0]    bf_res_b,
  output logic                 conflict_err,
  output logic                 done
);
  // Internal events, named for the assertions.
  logic              wr_valid, wr_last, conflict_now;
  logic [ROW_W-1:0]  wr_row_a, wr_row_b;
  logic [BANK_W-1:0] wr_bank_a, wr_bank_b;

  bfs_wb_pipe #(.ROW_W(ROW_W), .BANK_W(BANK_W), .LAT(LAT)) u_pipe (
    .clk(clk), .rst_n(rst_n),
    .in_valid(op_valid), .in_last(op_last),
    .in_row_a(op_row_a), .in_bank_a(op_bank_a),
    .in_row_b(op_row_b), .in_bank_b(op_bank_b),
    .wr_valid(wr_valid), .wr_last(wr_last),
    .wr_row_a(wr_row_a), .wr_bank_a(wr_bank_a),
    .wr_row_b(wr_row_b), .wr_bank_b(wr_bank_b)
  );

  bfs_conflict #(.BANK_W(BANK_W)) u_conf (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(op_valid), .rd_bank_a(op_bank_a), .rd_bank_b(op_bank_b),
    .wr_valid(wr_valid), .wr_bank_a(wr_bank_a), .wr_bank_b(wr_bank_b),
    .conflict_now(conflict_now), .conflict_err(conflict_err)
  );

  bfs_port_mux #(.ROW_W(ROW_W), .BANK_W(BANK_W), .DATA_W(DATA_W)) u_mux (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(op_valid),
    .rd_row_a(op_row_a), .rd_bank_a(op_bank_a),
    .rd_row_b(op_row_b), .rd_bank_b(op_bank_b),
    .wr_valid(wr_valid),
    .wr_row_a(wr_row_a), .wr_bank_a(wr_bank_a),
    .wr_row_b(wr_row_b), .wr_bank_b(wr_bank_b),
    .wr_data_a(bf_res_a), .wr_data_b(bf_res_b),
    .bank_sel(bank_sel), .bank_we(bank_we),
    .bank_addr(bank_addr), .bank_wdata(bank_wdata)
  );

  bfs_rd_steer #(.BANK_W(BANK_W), .DATA_W(DATA_W)) u_steer (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(op_valid), .rd_bank_a(op_bank_a), .rd_bank_b(op_bank_b),
    .bank_rdata(bank_rdata),
    .opnd_a(bf_opnd_a), .opnd_b(bf_opnd_b)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) done <= 1'b0;
    else        done <= wr_valid & wr_last;
  end

  assert_rd_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_bank_a != op_bank_b) |->
      (bank_sel[op_bank_a] && !bank_we[op_bank_a] &&
       bank_sel[op_bank_b] && !bank_we[op_bank_b]));
  assert_wb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !conflict_now) |-> (bank_we[wr_bank_a] && bank_we[wr_bank_b]));
  assert_four_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && wr_valid && !conflict_now) |-> $countones(bank_sel) == 4);
  assert_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && !wr_valid) |-> bank_sel == '0);
endmodule

// File: tb/bfs_sched_tb.sv
module bfs_sched_tb;
  localparam int ROW_W = 3, BANK_W = 2, DATA_W = 16, LAT = 1;
  localparam int NB = 4, NR = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic op_valid = 0, op_last = 0;
  logic [ROW_W-1:0] op_row_a = '0, op_row_b = '0;
  logic [BANK_W-1:0] op_bank_a = '0, op_bank_b = '0;
  logic [NB-1:0] bank_sel, bank_we;
  logic [NB*ROW_W-1:0] bank_addr;
  logic [NB*DATA_W-1:0] bank_wdata, bank_rdata;
  logic [DATA_W-1:0] bf_opnd_a, bf_opnd_b, bf_res_a, bf_res_b;
  logic conflict_err, done;

  int n_chk = 0, n_fail = 0;
  logic [DATA_W-1:0] mem [NB][NR];
  logic [DATA_W-1:0] ref_m [NB][NR];

  always #4 clk = ~clk;

  bfs_sched #(.ROW_W(ROW_W), .BANK_W(BANK_W), .DATA_W(DATA_W), .LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_last(op_last),
    .op_row_a(op_row_a), .op_bank_a(op_bank_a),
    .op_row_b(op_row_b), .op_bank_b(op_bank_b),
    .bank_sel(bank_sel), .bank_we(bank_we), .bank_addr(bank_addr),
    .bank_wdata(bank_wdata), .bank_rdata(bank_rdata),
    .bf_opnd_a(bf_opnd_a), .bf_opnd_b(bf_opnd_b),
    .bf_res_a(bf_res_a), .bf_res_b(bf_res_b),
    .conflict_err(conflict_err), .done(done));

  // Butterfly stub: sum and difference, results ready LAT=1 cycle after issue.
  assign bf_res_a = bf_opnd_a + bf_opnd_b;
  assign bf_res_b = bf_opnd_a - bf_opnd_b;

  // Four single-port banks with registered read data.
  always_ff @(posedge clk) begin
    for (int k = 0; k < NB; k++) begin
      if (bank_sel[k]) begin
        if (bank_we[k]) mem[k][bank_addr[k*ROW_W +: ROW_W]] <= bank_wdata[k*DATA_W +: DATA_W];
        else bank_rdata[k*DATA_W +: DATA_W] <= mem[k][bank_addr[k*ROW_W +: ROW_W]];
      end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int row_of(int k);
    return int'(bank_addr[k*ROW_W +: ROW_W]);
  endfunction

  task automatic preload();
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < NR; r++) begin
        mem[b][r]   = DATA_W'(r * 37 + b * 11 + 5);
        ref_m[b][r] = mem[b][r];
      end
  endtask

  // Stream 16 pairs. Even pairs use bank set s0, odd pairs the complement.
  task automatic run_pass(int mode);
    int pba = 0, pbb = 0, pra = 0, prb = 0;
    logic [DATA_W-1:0] pea = '0, peb = '0;
    for (int k = 0; k < 16; k++) begin
      int ba, bb, ra, rb;
      logic [DATA_W-1:0] ea, eb;
      if (mode == 0) begin
        ba = (k % 2) * 2; bb = ba + 1;
        if (((k >> 1) & 1) == 1) begin ba = ba + 1; bb = bb - 1; end
        ra = k >> 1; rb = k >> 1;
      end else begin
        ba = k % 2; bb = ba + 2;
        ra = k >> 1; rb = ((k >> 1) + 3) % NR;
      end
      ea = ref_m[ba][ra]; eb = ref_m[bb][rb];
      ref_m[ba][ra] = ea + eb; ref_m[bb][rb] = ea - eb;
      @(negedge clk);
      op_valid = 1; op_last = (k == 15);
      op_bank_a = BANK_W'(ba); op_bank_b = BANK_W'(bb);
      op_row_a = ROW_W'(ra); op_row_b = ROW_W'(rb);
      #1;
      chk(bank_sel[ba] && !bank_we[ba] && row_of(ba) == ra, "R2 read A port", row_of(ba), ra);
      chk(bank_sel[bb] && !bank_we[bb] && row_of(bb) == rb, "R2 read B port", row_of(bb), rb);
      if (k > 0) begin
        chk(bank_sel == 4'hF && conflict_err == 0, "R5 four distinct banks", int'(bank_sel), 15);
        chk(bank_we[pba] && row_of(pba) == pra && bank_we[pbb] && row_of(pbb) == prb,
            "R3 writeback place", int'(bank_we), (1 << pba) | (1 << pbb));
        chk(bf_opnd_a == pea && bf_opnd_b == peb, "R4 steer", int'(bf_opnd_a), int'(pea));
      end
      pba = ba; pbb = bb; pra = ra; prb = rb; pea = ea; peb = eb;
    end
    @(negedge clk);
    op_valid = 0; op_last = 0;
    #1;
    chk(bank_sel == 4'((1 << pba) | (1 << pbb)) && bank_we == bank_sel, "R9 drain writes only",
        int'(bank_sel), (1 << pba) | (1 << pbb));
    chk(done == 0, "R9 done not early", int'(done), 0);
    chk(bf_opnd_a == pea && bf_opnd_b == peb, "R4 steer last", int'(bf_opnd_a), int'(pea));
    @(negedge clk); #1;
    chk(done == 1, "R9 done pulse", int'(done), 1);
    chk(bank_sel == 0, "R10 idle", int'(bank_sel), 0);
    @(negedge clk); #1;
    chk(done == 0, "R9 done one cycle", int'(done), 0);
    for (int b = 0; b < NB; b++)
      for (int r = 0; r < NR; r++)
        chk(mem[b][r] == ref_m[b][r], "R3 memory image", int'(mem[b][r]), int'(ref_m[b][r]));
    chk(conflict_err == 0, "R5 no conflict", int'(conflict_err), 0);
  endtask

  initial begin
    fork
      begin
        preload();
        repeat (3) @(negedge clk);
        #1;
        chk(bank_sel == 0 && bank_we == 0 && conflict_err == 0 && done == 0,
            "R1 reset state", int'(bank_sel), 0);
        @(negedge clk); rst_n = 1;
        run_pass(0);
        run_pass(1);
        // Collision: pair (banks 0,1) then pair (banks 1,2).
        @(negedge clk);
        op_valid = 1; op_bank_a = 0; op_bank_b = 1; op_row_a = 1; op_row_b = 2;
        @(negedge clk);
        op_bank_a = 1; op_bank_b = 2; op_row_a = 5; op_row_b = 6;
        #1;
        chk(bank_sel[1] && !bank_we[1] && row_of(1) == 5, "R7 read wins bank1", row_of(1), 5);
        chk(bank_we[0] && row_of(0) == 1, "R7 unblocked write bank0", row_of(0), 1);
        chk(conflict_err == 0, "R6 not yet set", int'(conflict_err), 0);
        @(negedge clk);
        op_bank_a = 2; op_bank_b = 2; op_row_a = 3; op_row_b = 4;
        #1;
        chk(conflict_err == 1, "R6 set", int'(conflict_err), 1);
        chk(bank_sel == 4'b0110 && bank_we == 4'b0010, "R8 ports", int'(bank_sel), 6);
        chk(row_of(2) == 3, "R8 operand A row", row_of(2), 3);
        @(negedge clk); op_valid = 0;
        repeat (3) @(negedge clk);
        #1;
        chk(conflict_err == 1, "R6 sticky", int'(conflict_err), 1);
        chk(bank_sel == 0, "R10 idle after drain", int'(bank_sel), 0);
        rst_n = 0;
        @(negedge clk); #1;
        chk(conflict_err == 0 && done == 0, "R1 reset clears", int'(conflict_err), 0);
      end
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule